// File: doc/BRIEF.md
# Deferred-Fault Register File

This block is a general-purpose register file in which every register carries a one-bit deferred-fault flag. It lets a compiler hoist loads above the branches that guard them. A speculative load that faults does not trap. It writes its destination, marks the register as poisoned and carries on. Arithmetic that reads a poisoned register produces a poisoned result, so the fault spreads down the dependence chain without any trap. Only an explicit check operation acts on the flag. The check falls through on a clean register. On a poisoned register it redirects to a fix-up target supplied with the check.

One operation enters per cycle, together with the memory response for loads: the data word and a fault indication. The ALU sits outside the block. It reads the two read ports and returns its result on `aluData` in the same cycle. A non-speculative load that faults raises a trap pulse and leaves its destination unchanged. Writes are staged one cycle before they reach the array. The staged write is bypassed to both read ports, so the next operation already sees the new value and its flag.

Top module: `deferred_fault_rf`

## Requirements
- R1: While reset is held, every register reads as zero and clean, and `chkValid`, `chkRedirect` and `trapValid` are low.
- R2: Register 0 always reads as zero with a clear flag. Any write to it is discarded, and a check on it falls through.
- R3: A load (opKind 2) or a speculative load (opKind 3) without a fault writes `memData` to its destination and clears that register's flag.
- R4: A speculative load (opKind 3) with `memFault` high writes zero to its destination and sets the flag. `trapValid` stays low one cycle later.
- R5: A load (opKind 2) with `memFault` high raises `trapValid` for exactly one cycle, one cycle after the operation, and leaves its destination unchanged.
- R6: An ALU operation (opKind 1) writes `aluData` to its destination. The written flag is the OR of the flags of its two sources (srcA, srcB), and no trap is raised.
- R7: A check (opKind 4) on srcA produces `chkValid` one cycle later. If srcA is poisoned, `chkRedirect` is 1 and `chkTarget` equals `fixupTarget`. If srcA is clean, `chkRedirect` is 0 and `chkTarget` is zero.
- R8: A register written by an operation in cycle t reads back on both ports with its new value and flag in cycle t+1.
- R9: An operation with `opValid` low, or with an unused opKind (0, 5, 6 or 7), changes no register and raises neither `chkValid` nor `trapValid`.
- R10: A check leaves the flag of its register unchanged, so repeated checks on a poisoned register keep redirecting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | An operation is presented this cycle |
| opKind | input | 3 | 1 ALU, 2 load, 3 speculative load, 4 check, other values unused |
| dstSel | input | IDX_W | Destination register |
| srcASel | input | IDX_W | Read port A register (the checked register for a check) |
| srcBSel | input | IDX_W | Read port B register |
| aluData | input | DATA_W | Result of the external ALU |
| memData | input | DATA_W | Load data from memory |
| memFault | input | 1 | Load faulted (page fault or invalid address) |
| fixupTarget | input | PC_W | Redirect address carried by a check |
| rdAData | output | DATA_W | Read port A value |
| rdAPoison | output | 1 | Read port A flag |
| rdBData | output | DATA_W | Read port B value |
| rdBPoison | output | 1 | Read port B flag |
| chkValid | output | 1 | Check result valid |
| chkRedirect | output | 1 | Checked register was poisoned |
| chkTarget | output | PC_W | Fix-up address on redirect, else zero |
| trapValid | output | 1 | Immediate trap from a faulting non-speculative load |

## Verification
The assertions rely on a few input rules. `memFault` only has meaning on load operations. `aluData` is a plain value with no flag of its own, so all poison information comes from the read ports. `opKind` is sampled only while `opValid` is high. The stimulus drives every input at the falling edge and holds it for the whole cycle. It raises `memFault` on loads and, separately, on an invalid operation to confirm that nothing happens. It computes every expected flag and read value from a model of the register state held in the bench. Dependent operations are issued back to back, so the poison chains pass through the bypass path rather than through the array.

// File: rtl/dfrf_pkg.sv
package dfrf_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ALU   = 3'd1,
    OP_LOAD  = 3'd2,
    OP_SPEC  = 3'd3,
    OP_CHECK = 3'd4
  } opKind_e;

  // Strobes from control to datapath for one operation
  typedef struct packed {
    logic wrEn;       // stage a register write
    logic wrFromAlu;  // data from ALU, flag from source OR
    logic wrZero;     // faulted speculative load: data forced to zero
    logic wrPoisonSet;// force flag set
    logic chkEn;      // resolve a check on read port A
  } ctrlStrobe_t;

endpackage

// File: rtl/dfrf_ctrl.sv
module dfrf_ctrl
  import dfrf_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic [IDX_W-1:0]  dstSel,
  input  logic              memFault,
  output ctrlStrobe_t       stb,
  output logic              trapValid
);

  logic dstLive;
  logic trapNext;

  assign dstLive = (dstSel != '0);

  always_comb begin
    stb = '0;
    trapNext = 1'b0;
    if (opValid) begin
      case (opKind)
        OP_ALU: begin
          stb.wrEn      = dstLive;
          stb.wrFromAlu = 1'b1;
        end
        OP_LOAD: begin
          if (memFault) trapNext = 1'b1;
          else          stb.wrEn = dstLive;
        end
        OP_SPEC: begin
          stb.wrEn        = dstLive;
          stb.wrZero      = memFault;
          stb.wrPoisonSet = memFault;
        end
        OP_CHECK: stb.chkEn = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trapValid <= 1'b0;
    else        trapValid <= trapNext;
  end

  // R5: a faulting plain load traps on the next cycle
  assert_trap_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opKind == OP_LOAD && memFault) |=> trapValid);

  // R4: a speculative load never traps, faulting or not
  assert_spec_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opKind == OP_SPEC) |=> !trapValid);

  // R2: no write is ever staged for register 0
  assert_no_zero_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrEn |-> dstSel != '0);

  // R9: invalid slot produces no trap
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |=> !trapValid);

endmodule

// File: rtl/dfrf_data.sv
module dfrf_data
  import dfrf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  parameter int PC_W    = 32,
  parameter int IDX_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       stb,
  input  logic [IDX_W-1:0]  dstSel,
  input  logic [IDX_W-1:0]  srcASel,
  input  logic [IDX_W-1:0]  srcBSel,
  input  logic [DATA_W-1:0] aluData,
  input  logic [DATA_W-1:0] memData,
  input  logic [PC_W-1:0]   fixupTarget,
  output logic [DATA_W-1:0] rdAData,
  output logic              rdAPoison,
  output logic [DATA_W-1:0] rdBData,
  output logic              rdBPoison,
  output logic              chkValid,
  output logic              chkRedirect,
  output logic [PC_W-1:0]   chkTarget
);

  localparam int PORTS = 2;

  logic [DATA_W-1:0] regData [REG_CNT];
  logic [REG_CNT-1:0] regPoison;

  // staged write, committed to the array one cycle later
  logic              wbValid;
  logic [IDX_W-1:0]  wbIdx;
  logic [DATA_W-1:0] wbData;
  logic              wbPoison;

  logic [IDX_W-1:0]  rdSel  [PORTS];
  logic [DATA_W-1:0] rdData [PORTS];
  logic [PORTS-1:0]  rdPois;

  assign rdSel[0] = srcASel;
  assign rdSel[1] = srcBSel;

  for (genvar gp = 0; gp < PORTS; gp++) begin : g_rd
    always_comb begin
      if (rdSel[gp] == '0) begin
        rdData[gp] = '0;
        rdPois[gp] = 1'b0;
      end else if (wbValid && wbIdx == rdSel[gp]) begin
        rdData[gp] = wbData;
        rdPois[gp] = wbPoison;
      end else begin
        rdData[gp] = regData[rdSel[gp]];
        rdPois[gp] = regPoison[rdSel[gp]];
      end
    end
  end

  assign rdAData   = rdData[0];
  assign rdAPoison = rdPois[0];
  assign rdBData   = rdData[1];
  assign rdBPoison = rdPois[1];

  // write staging
  logic [DATA_W-1:0] wrDataNext;
  logic              wrPoisonNext;

  always_comb begin
    if (stb.wrZero)         wrDataNext = '0;
    else if (stb.wrFromAlu) wrDataNext = aluData;
    else                    wrDataNext = memData;
    wrPoisonNext = stb.wrPoisonSet | (stb.wrFromAlu & (|rdPois));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wbValid  <= 1'b0;
      wbIdx    <= '0;
      wbData   <= '0;
      wbPoison <= 1'b0;
    end else begin
      wbValid  <= stb.wrEn;
      wbIdx    <= dstSel;
      wbData   <= wrDataNext;
      wbPoison <= wrPoisonNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < REG_CNT; i++) regData[i] <= '0;
      regPoison <= '0;
    end else if (wbValid) begin
      regData[wbIdx]   <= wbData;
      regPoison[wbIdx] <= wbPoison;
    end
  end

  // check resolution, registered
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chkValid    <= 1'b0;
      chkRedirect <= 1'b0;
      chkTarget   <= '0;
    end else begin
      chkValid    <= stb.chkEn;
      chkRedirect <= stb.chkEn & rdPois[0];
      chkTarget   <= (stb.chkEn & rdPois[0]) ? fixupTarget : '0;
    end
  end

  // R7: every check yields a result on the next cycle
  assert_chk_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.chkEn |=> chkValid);

  // R7: a poisoned checked register always redirects
  assert_chk_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.chkEn && rdPois[0]) |=> (chkRedirect && chkTarget == $past(fixupTarget)));

  // R7: redirect never appears without a valid result
  assert_redirect_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chkRedirect |-> chkValid);

  // R6: a poisoned ALU source yields a poisoned staged result
  assert_alu_spread_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrEn && stb.wrFromAlu && (|rdPois)) |=> wbPoison);

  // R2: register 0 reads as a clean zero on port A
  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (srcASel == '0) |-> (rdAData == '0 && !rdAPoison));

  // R8: a staged write is visible on the next cycle through port B
  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stb.wrEn) && srcBSel == $past(dstSel)) |-> rdBPoison == $past(wrPoisonNext));

endmodule

// File: rtl/deferred_fault_rf.sv
module deferred_fault_rf
  import dfrf_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  parameter int PC_W    = 32,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opValid,
  input  logic [2:0]        opKind,
  input  logic [IDX_W-1:0]  dstSel,
  input  logic [IDX_W-1:0]  srcASel,
  input  logic [IDX_W-1:0]  srcBSel,
  input  logic [DATA_W-1:0] aluData,
  input  logic [DATA_W-1:0] memData,
  input  logic              memFault,
  input  logic [PC_W-1:0]   fixupTarget,
  output logic [DATA_W-1:0] rdAData,
  output logic              rdAPoison,
  output logic [DATA_W-1:0] rdBData,
  output logic              rdBPoison,
  output logic              chkValid,
  output logic              chkRedirect,
  output logic [PC_W-1:0]   chkTarget,
  output logic              trapValid
);

  ctrlStrobe_t stb;

  dfrf_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .opValid  (opValid),
    .opKind   (opKind),
    .dstSel   (dstSel),
    .memFault (memFault),
    .stb      (stb),
    .trapValid(trapValid)
  );

  dfrf_data #(
    .DATA_W (DATA_W),
    .REG_CNT(REG_CNT),
    .PC_W   (PC_W),
    .IDX_W  (IDX_W)
  ) uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .stb        (stb),
    .dstSel     (dstSel),
    .srcASel    (srcASel),
    .srcBSel    (srcBSel),
    .aluData    (aluData),
    .memData    (memData),
    .fixupTarget(fixupTarget),
    .rdAData    (rdAData),
    .rdAPoison  (rdAPoison),
    .rdBData    (rdBData),
    .rdBPoison  (rdBPoison),
    .chkValid   (chkValid),
    .chkRedirect(chkRedirect),
    .chkTarget  (chkTarget)
  );

endmodule

// File: tb/sim_deferred_fault_rf.sv
module sim_deferred_fault_rf;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opKind = 3'd0;
  logic [4:0]  dstSel = '0, srcASel = '0, srcBSel = '0;
  logic [31:0] aluData = '0, memData = '0, fixupTarget = '0;
  logic        memFault = 1'b0;
  logic [31:0] rdAData, rdBData, chkTarget;
  logic        rdAPoison, rdBPoison, chkValid, chkRedirect, trapValid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  deferred_fault_rf u0 (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opKind(opKind),
    .dstSel(dstSel), .srcASel(srcASel), .srcBSel(srcBSel),
    .aluData(aluData), .memData(memData), .memFault(memFault),
    .fixupTarget(fixupTarget), .rdAData(rdAData), .rdAPoison(rdAPoison),
    .rdBData(rdBData), .rdBPoison(rdBPoison), .chkValid(chkValid),
    .chkRedirect(chkRedirect), .chkTarget(chkTarget), .trapValid(trapValid)
  );

  typedef struct {
    logic        cv;
    logic        cr;
    logic [31:0] ct;
    logic        tr;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  logic [31:0] mData [32];
  logic        mPois [32];

  task automatic report(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: apply one operation, verify read ports against model, push expectation
  task automatic runOp(input logic v, input logic [2:0] k, input int d, input int a,
                       input int b, input logic [31:0] alu, input logic [31:0] mem,
                       input logic flt, input logic [31:0] fix, input string tag);
    expItem_t e;
    @(negedge clk);
    opValid = v; opKind = k; dstSel = d[4:0]; srcASel = a[4:0]; srcBSel = b[4:0];
    aluData = alu; memData = mem; memFault = flt; fixupTarget = fix;
    #1;
    report(rdAData == mData[a] && rdAPoison == mPois[a], tag, "portA",
           {31'd0, rdAPoison, rdAData}, {31'd0, mPois[a], mData[a]});
    report(rdBData == mData[b] && rdBPoison == mPois[b], tag, "portB",
           {31'd0, rdBPoison, rdBData}, {31'd0, mPois[b], mData[b]});
    e.cv = 1'b0; e.cr = 1'b0; e.ct = '0; e.tr = 1'b0; e.tag = tag;
    if (v) begin
      case (k)
        3'd1: if (d != 0) begin mData[d] = alu; mPois[d] = mPois[a] | mPois[b]; end
        3'd2: if (flt) e.tr = 1'b1;
              else if (d != 0) begin mData[d] = mem; mPois[d] = 1'b0; end
        3'd3: if (d != 0) begin mData[d] = flt ? 32'd0 : mem; mPois[d] = flt; end
        3'd4: begin e.cv = 1'b1; e.cr = mPois[a]; e.ct = mPois[a] ? fix : 32'd0; end
        default: ;
      endcase
    end
    expQ.push_back(e);
  endtask

  // monitor: compare registered outputs just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        report(chkValid == e.cv && chkRedirect == e.cr && chkTarget == e.ct &&
               trapValid == e.tr, e.tag, "chk/trap",
               {29'd0, chkValid, chkRedirect, trapValid, chkTarget},
               {29'd0, e.cv, e.cr, e.tr, e.ct});
      end
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 32; i++) begin mData[i] = '0; mPois[i] = 1'b0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    srcASel = 5'd7; srcBSel = 5'd31; #1;
    // R1: reset state
    report(rdAData == 0 && !rdAPoison && rdBData == 0 && !rdBPoison, "R1", "reset read",
           {rdAPoison, rdBPoison, rdAData}, 64'd0);
    report(!chkValid && !chkRedirect && !trapValid, "R1", "reset outputs",
           {chkValid, chkRedirect, trapValid}, 64'd0);
    rst_n = 1'b1;

    runOp(1, 3'd0, 0, 7, 31, 0, 0, 0, 0, "R1");
    runOp(1, 3'd2, 1, 0, 0, 0, 32'h1111, 0, 0, "R3");           // clean load
    runOp(1, 3'd1, 2, 1, 0, 32'h22, 0, 0, 0, "R8");              // bypass read of r1
    runOp(1, 3'd3, 3, 2, 1, 0, 32'hDEAD, 1, 0, "R4");            // faulting spec load
    runOp(1, 3'd1, 4, 3, 1, 32'h44, 0, 0, 0, "R6");              // poison from srcA
    runOp(1, 3'd1, 5, 2, 4, 32'h55, 0, 0, 0, "R6");              // poison from srcB
    runOp(1, 3'd1, 6, 1, 2, 32'h66, 0, 0, 0, "R6");              // clean sources
    runOp(1, 3'd4, 0, 5, 6, 0, 0, 0, 32'h400, "R7");             // redirect
    runOp(1, 3'd4, 0, 6, 5, 0, 0, 0, 32'h800, "R7");             // fall through
    runOp(1, 3'd2, 2, 2, 0, 0, 32'h9999, 1, 0, "R5");            // faulting plain load
    runOp(1, 3'd0, 0, 2, 2, 0, 0, 0, 0, "R5");                   // r2 unchanged, trap ends
    runOp(1, 3'd4, 0, 0, 0, 0, 0, 0, 32'h123, "R2");             // check r0
    runOp(1, 3'd1, 0, 4, 0, 32'h77, 0, 0, 0, "R2");              // write r0 discarded
    runOp(1, 3'd3, 0, 0, 0, 0, 32'h5, 1, 0, "R2");               // spec fault into r0
    runOp(1, 3'd4, 0, 0, 4, 0, 0, 0, 32'h321, "R2");
    runOp(1, 3'd3, 3, 3, 0, 0, 32'h33, 0, 0, "R3");              // clean spec load clears
    runOp(1, 3'd4, 0, 3, 3, 0, 0, 0, 32'h900, "R3");
    runOp(0, 3'd3, 1, 1, 0, 32'hAA, 32'hBB, 1, 0, "R9");         // not valid
    runOp(1, 3'd5, 1, 1, 0, 32'hAA, 32'hBB, 1, 32'h10, "R9");
    runOp(1, 3'd6, 1, 1, 0, 32'hAA, 32'hBB, 0, 32'h10, "R9");
    runOp(1, 3'd7, 1, 1, 4, 32'hAA, 32'hBB, 1, 32'h10, "R9");
    runOp(1, 3'd0, 1, 1, 4, 32'hAA, 32'hBB, 1, 32'h10, "R9");
    runOp(1, 3'd4, 0, 4, 0, 0, 0, 0, 32'hA00, "R10");
    runOp(1, 3'd4, 0, 4, 0, 0, 0, 0, 32'hB00, "R10");            // still poisoned
    runOp(1, 3'd1, 7, 4, 5, 32'h12, 0, 0, 0, "R10");
    runOp(1, 3'd4, 0, 7, 4, 0, 0, 0, 32'hC00, "R10");
    runOp(1, 3'd2, 4, 0, 0, 0, 32'h4444, 0, 0, "R3");            // clean load clears r4
    runOp(1, 3'd4, 0, 4, 7, 0, 0, 0, 32'hD00, "R3");
    runOp(0, 3'd0, 0, 4, 7, 0, 0, 0, 0, "R8");
    runOp(0, 3'd0, 0, 1, 2, 0, 0, 0, 0, "R9");
    wait (expQ.size() == 0);
    @(posedge clk); #3;
    finishRun();
  end

endmodule